// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns two external interrupt pins into interrupt requests for a CPU. Channel A is sampled through a synchronizer and can raise a request on a low level, on any change, on a falling edge or on a rising edge. Channel B reacts only to edges. A polarity bit picks the direction, and the edge is captured by a flop clocked from the pin itself, so a pulse shorter than a clock period is still recorded.

Software sets up the block through a two-address register port. The control register holds the channel A mode, the channel B polarity, one enable per channel and a global enable. The flag register reads the pending state of both channels and clears a flag when a 1 is written to its bit. The CPU can also clear a channel's flag with that channel's acknowledge input. A channel drives its request output only while its pending state, its own enable and the global enable are all set.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the control register reads 0x00, the flag register reads 0x00, and both request outputs are low.
- R2: With control bits [1:0] = 00, channel A is pending exactly while its synchronized pin is low. Flag bit 0 and the request drop once the pin is high again, and no latched state remains.
- R3: With control bits [1:0] = 01, any change of the channel A pin sets the channel A flag (flag register bit 0).
- R4: With control bits [1:0] = 10, a falling edge on pin A sets flag bit 0 and a rising edge does not.
- R5: With control bits [1:0] = 11, a rising edge on pin A sets flag bit 0 and a falling edge does not.
- R6: A request output is high only when the global enable (control bit 7) and the channel's enable (bit 4 for A, bit 5 for B) are both set and the channel is pending. Clearing an enable does not clear the flag.
- R7: Channel B sets flag register bit 1 on a falling pin edge when control bit 2 is 0, and on a rising pin edge when it is 1. This holds even for a pulse shorter than one clock period.
- R8: Writing control bit 2 from 0 to 1 while pin B is high sets flag bit 1. Writing it from 1 to 0 while pin B is high does not.
- R9: A write to the flag register (address 1) clears each flag whose data bit is 1. Data bits that are 0 leave their flag unchanged.
- R10: A one-cycle pulse on a channel's acknowledge input clears that channel's flag.
- R11: When a new trigger event and a clear (write or acknowledge) act on a flag in the same cycle, the flag ends up set.
- R12: A write to address 0 stores all eight data bits, and they read back at address 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_a | input | 1 | Channel A interrupt pin (asynchronous to clk) |
| pin_b | input | 1 | Channel B interrupt pin (edge captured asynchronously) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| ack_a | input | 1 | CPU acknowledge for channel A |
| ack_b | input | 1 | CPU acknowledge for channel B |
| irq_a | output | 1 | Channel A interrupt request |
| irq_b | output | 1 | Channel B interrupt request |

## Verification
The assertions assume that a flag can only be set by an event already seen in the clock domain. For channel B, this means at most one captured edge in every two clock periods, so that toggles in the capture flop never cancel out before the synchronizer sees them. The stimulus leaves at least four cycles between pin transitions. The only exception is a single short channel B pulse, whose two pin edges produce just one edge of the selected polarity. Register writes and acknowledges are driven between clock edges and last exactly one cycle.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_FLAG = 1'b1;

  localparam int BIT_MODE_LO = 0;
  localparam int BIT_POL_B   = 2;
  localparam int BIT_EN_A    = 4;
  localparam int BIT_EN_B    = 5;
  localparam int BIT_GIE     = 7;
  localparam int BIT_FLAG_A  = 0;
  localparam int BIT_FLAG_B  = 1;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ext_irq_chan_a.sv
module ext_irq_chan_a
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin,
  input  sense_e mode,
  input  logic   clr,
  input  logic   ack,
  output logic   pend
);
  logic pin_s;
  logic prev_q, prev_d;
  logic flag_q, flag_d, flag_en;
  logic rise, fall, evt;

  ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s)
  );

  always_comb begin
    prev_d = pin_s;
    rise   = pin_s & ~prev_q;
    fall   = ~pin_s & prev_q;
    unique case (mode)
      SENSE_ANY:  evt = rise | fall;
      SENSE_FALL: evt = fall;
      SENSE_RISE: evt = rise;
      default:    evt = 1'b0;
    endcase
    flag_en = evt | clr | ack;
    flag_d  = evt;
    pend    = (mode == SENSE_LOW) ? ~pin_s : flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  // R3 / R11: an event always leaves the flag set
  p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q);
  // R10: a clear without a competing event empties the flag
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && (clr || ack)) |=> !flag_q);
endmodule

// File: rtl/ext_irq_chan_b.sv
module ext_irq_chan_b #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  input  logic clr,
  input  logic ack,
  output logic pend
);
  logic trig;
  logic tog_q;
  logic tog_s;
  logic seen_q, seen_d;
  logic edge_det;
  logic flag_q, flag_d, flag_en;

  // Selected edge always appears as a rising edge of trig
  assign trig = pol ? pin : ~pin;

  always_ff @(posedge trig or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= ~tog_q;
  end

  ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(tog_q), .q(tog_s)
  );

  always_comb begin
    seen_d   = tog_s;
    edge_det = tog_s ^ seen_q;
    flag_en  = edge_det | clr | ack;
    flag_d   = edge_det;
    pend     = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  // R7 / R11: a synchronized edge wins over any clear
  p_edge_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_det |=> flag_q);
  // R9: a clear without a new edge empties the flag
  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_det && (clr || ack)) |=> !flag_q);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ack_a,
  input  logic             ack_b,
  output logic             irq_a,
  output logic             irq_b
);
  logic             rst_int_n;
  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic             ctrl_en;
  logic             clr_a, clr_b;
  logic             pend_a, pend_b;
  sense_e           mode_a;

  ext_irq_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  always_comb begin
    ctrl_en = reg_wr && (reg_addr == ADDR_CTRL);
    ctrl_d  = reg_wdata;
    clr_a   = reg_wr && (reg_addr == ADDR_FLAG) && reg_wdata[BIT_FLAG_A];
    clr_b   = reg_wr && (reg_addr == ADDR_FLAG) && reg_wdata[BIT_FLAG_B];
    mode_a  = sense_e'(ctrl_q[BIT_MODE_LO +: 2]);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  ext_irq_chan_a #(.SYNC_STAGES(SYNC_STAGES)) u_chan_a (
    .clk(clk), .rst_n(rst_int_n), .pin(pin_a), .mode(mode_a),
    .clr(clr_a), .ack(ack_a), .pend(pend_a)
  );

  ext_irq_chan_b #(.SYNC_STAGES(SYNC_STAGES)) u_chan_b (
    .clk(clk), .rst_n(rst_int_n), .pin(pin_b), .pol(ctrl_q[BIT_POL_B]),
    .clr(clr_b), .ack(ack_b), .pend(pend_b)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_FLAG) begin
      reg_rdata[BIT_FLAG_A] = pend_a;
      reg_rdata[BIT_FLAG_B] = pend_b;
    end else begin
      reg_rdata = ctrl_q;
    end
    irq_a = ctrl_q[BIT_GIE] & ctrl_q[BIT_EN_A] & pend_a;
    irq_b = ctrl_q[BIT_GIE] & ctrl_q[BIT_EN_B] & pend_b;
  end

  // R12: a control write is stored in full
  p_ctrl_wr_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_wr && reg_addr == ADDR_CTRL) |=> (ctrl_q == $past(reg_wdata)));
endmodule

// File: tb/test_ext_irq_sense.sv
`timescale 1ns/1ps
module test_ext_irq_sense;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin_a, pin_b;
  logic       reg_wr, reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       ack_a, ack_b;
  logic       irq_a, irq_b;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  ext_irq_sense i_ext_irq_sense (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ack_a(ack_a), .ack_b(ack_b),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic pulse_ack(input bit chan_b);
    @(negedge clk);
    if (chan_b) ack_b = 1'b1; else ack_a = 1'b1;
    @(negedge clk);
    ack_a = 1'b0; ack_b = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(1'b0, v); check("R1 ctrl", v, 8'h00);
    rd(1'b1, v); check("R1 flags", v, 8'h00);
    check("R1 irq", {6'b0, irq_b, irq_a}, 8'h00);
  endtask

  task automatic t_ctrl_rw;
    logic [7:0] v;
    wr(1'b0, 8'h48);
    rd(1'b0, v); check("R12 readback", v, 8'h48);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_level;
    logic [7:0] v;
    wr(1'b0, 8'h90);
    pin_a = 1'b0; cyc(4);
    rd(1'b1, v); check("R2 low pending", v, 8'h01);
    check("R2 irq low", {7'b0, irq_a}, 8'h01);
    pin_a = 1'b1; cyc(4);
    rd(1'b1, v); check("R2 released", v, 8'h00);
    check("R2 irq drop", {7'b0, irq_a}, 8'h00);
  endtask

  task automatic t_any;
    logic [7:0] v;
    wr(1'b0, 8'h91);
    pin_a = 1'b0; cyc(4);
    rd(1'b1, v); check("R3 fall seen", v, 8'h01);
    wr(1'b1, 8'h01);
    pin_a = 1'b1; cyc(4);
    rd(1'b1, v); check("R3 rise seen", v, 8'h01);
    wr(1'b1, 8'h01);
  endtask

  task automatic t_fall;
    logic [7:0] v;
    wr(1'b0, 8'h92);
    pin_a = 1'b0; cyc(4);
    rd(1'b1, v); check("R4 fall sets", v, 8'h01);
    wr(1'b1, 8'h01);
    pin_a = 1'b1; cyc(4);
    rd(1'b1, v); check("R4 rise ignored", v, 8'h00);
  endtask

  task automatic t_rise;
    logic [7:0] v;
    wr(1'b0, 8'h93);
    pin_a = 1'b0; cyc(4);
    rd(1'b1, v); check("R5 fall ignored", v, 8'h00);
    pin_a = 1'b1; cyc(4);
    rd(1'b1, v); check("R5 rise sets", v, 8'h01);
  endtask

  task automatic t_gate;
    logic [7:0] v;
    wr(1'b0, 8'h13);
    check("R6 no gie", {7'b0, irq_a}, 8'h00);
    wr(1'b0, 8'h83);
    check("R6 no mask", {7'b0, irq_a}, 8'h00);
    rd(1'b1, v); check("R6 flag kept", v, 8'h01);
    wr(1'b0, 8'h93);
    check("R6 both set", {7'b0, irq_a}, 8'h01);
    wr(1'b1, 8'h01);
  endtask

  task automatic t_chan_b;
    logic [7:0] v;
    wr(1'b0, 8'hA0);
    @(negedge clk); pin_b = 1'b0; #2 pin_b = 1'b1;
    cyc(4);
    rd(1'b1, v); check("R7 short falling pulse", v, 8'h02);
    check("R7 irq_b", {7'b0, irq_b}, 8'h01);
    wr(1'b1, 8'h02);
    wr(1'b0, 8'hA4); cyc(4);
    rd(1'b1, v); check("R8 polarity change sets", v, 8'h02);
    wr(1'b1, 8'h02);
    pin_b = 1'b0; cyc(4);
    rd(1'b1, v); check("R7 falling ignored pol1", v, 8'h00);
    pin_b = 1'b1; cyc(4);
    rd(1'b1, v); check("R7 rising pol1", v, 8'h02);
    wr(1'b1, 8'h02);
    wr(1'b0, 8'hA0); cyc(4);
    rd(1'b1, v); check("R8 back to falling no set", v, 8'h00);
  endtask

  task automatic t_w1c;
    logic [7:0] v;
    @(negedge clk); pin_b = 1'b0; #2 pin_b = 1'b1;
    cyc(4);
    wr(1'b1, 8'h00);
    rd(1'b1, v); check("R9 zero write", v, 8'h02);
    wr(1'b1, 8'h01);
    rd(1'b1, v); check("R9 other bit", v, 8'h02);
    wr(1'b1, 8'h02);
    rd(1'b1, v); check("R9 one clears", v, 8'h00);
  endtask

  task automatic t_ack;
    logic [7:0] v;
    @(negedge clk); pin_b = 1'b0; #2 pin_b = 1'b1;
    cyc(4);
    pulse_ack(1'b1);
    rd(1'b1, v); check("R10 ack_b", v, 8'h00);
    check("R10 irq_b drop", {7'b0, irq_b}, 8'h00);
    wr(1'b0, 8'h93);
    pin_a = 1'b0; cyc(4);
    pin_a = 1'b1; cyc(4);
    rd(1'b1, v); check("R10 a pending", v, 8'h01);
    pulse_ack(1'b0);
    rd(1'b1, v); check("R10 ack_a", v, 8'h00);
  endtask

  task automatic t_set_wins;
    logic [7:0] v;
    wr(1'b0, 8'h91);
    pin_a = 1'b0; cyc(4);
    @(negedge clk); pin_a = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h01; ack_a = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00; ack_a = 1'b0;
    rd(1'b1, v); check("R11 set beats clear", v, 8'h01);
    wr(1'b1, 8'h01);
    rd(1'b1, v); check("R11 later clear", v, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; pin_a = 1'b1; pin_b = 1'b1;
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = 8'h00;
    ack_a = 1'b0; ack_b = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(6);
    t_reset();
    t_ctrl_rw();
    t_level();
    t_any();
    t_fall();
    t_rise();
    t_gate();
    t_chan_b();
    t_w1c();
    t_ack();
    t_set_wins();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100us;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule